// File: doc/BRIEF.md
# Protection Feedback Latch

This block is a tiny register that cartridge software probes to confirm it is running on the expected hardware. The CPU writes two bits into it, and the value it reads back carries one of them inverted. Address bit 0 of the write selects one of two actions. With A0 clear, both stored bits take the written data. With A0 set, only the low bit takes the written data. In that case the upper stored bit toggles whenever the low bit goes from 1 to 0.

The block sits on the CPU bus. It decodes the address, takes data on a one-cycle write strobe, and drives read data with an output enable only while a decoded read is active. Both stored bits come up cleared.

Top module: `prot_fb_latch`

## Requirements
- R1: After reset both stored bits are 0, so a decoded read returns 8'h04.
- R2: A write is decoded only when address bits [15:8] equal 8'h51. Bits [7:1] are don't-care. Any other write leaves the state unchanged.
- R3: A decoded write with address bit 0 = 0 stores data bit 0 as the edge bit and data bit 2 as the feedback bit.
- R4: A decoded write with address bit 0 = 1 stores data bit 0 as the edge bit and ignores data bit 2. The feedback bit inverts when the stored edge bit was 1 and the new data bit 0 is 0.
- R5: A decoded write with address bit 0 = 1 that does not take the edge bit from 1 to 0 leaves the feedback bit unchanged.
- R6: A read is decoded when (address & 16'hF300) == 16'h5100. During a decoded read, read_oe is 1 and bit 2 of the read data is the inverse of the stored feedback bit.
- R7: All read-data bits other than bit 2 are 0. When no decoded read is active, read_oe is 0 and the read data is 8'h00.
- R8: A read in the same cycle as a decoded write returns the feedback bit as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | Write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data |
| cpu_rdata_oe | output | 1 | High while read data is driven |

## Verification
A read and a write can fall in the same cycle, and the toggle case of R4 is then the one that matters. The bench sets the edge bit to 1 first. In a single cycle it then raises both strobes on address 16'h5101 with data 0, which both decode ranges accept. Read data sampled inside that cycle must still show the old feedback value. A separate read after the clock edge must show the toggled value.

// File: rtl/prot_fb_latch.sv
module prot_fb_latch #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] WR_MASK = 16'hFF00,
  parameter logic [AW-1:0] WR_BASE = 16'h5100,
  parameter logic [AW-1:0] RD_MASK = 16'hF300,
  parameter logic [AW-1:0] RD_BASE = 16'h5100,
  parameter int E_BIT = 0,
  parameter int F_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rdata_oe
);

  logic e_q, f_q;
  logic wr_hit, rd_hit, fall;

  assign wr_hit = cpu_wr && ((cpu_addr & WR_MASK) == WR_BASE);
  assign rd_hit = cpu_rd && ((cpu_addr & RD_MASK) == RD_BASE);
  assign fall   = e_q && !cpu_wdata[E_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_q <= 1'b0;
      f_q <= 1'b0;
    end else if (wr_hit) begin
      e_q <= cpu_wdata[E_BIT];
      if (!cpu_addr[0])
        f_q <= cpu_wdata[F_BIT];
      else if (fall)
        f_q <= !f_q;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (rd_hit) cpu_rdata[F_BIT] = !f_q;
  end
  assign cpu_rdata_oe = rd_hit;

  assert_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(f_q) && $stable(e_q));

  assert_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !cpu_addr[0] |=> f_q == $past(cpu_wdata[F_BIT]) && e_q == $past(cpu_wdata[E_BIT]));

  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && cpu_addr[0] && e_q && !cpu_wdata[E_BIT] |=> f_q != $past(f_q));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && cpu_addr[0] && !(e_q && !cpu_wdata[E_BIT]) |=> $stable(f_q));

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdata_oe |-> cpu_rdata == '0);

endmodule

// File: tb/prot_fb_latch_tb_top.sv
module prot_fb_latch_tb_top;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_wr = 0, cpu_rd = 0, cpu_rdata_oe;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  prot_fb_latch dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe));

  // {write address, write data, expected read data at 16'h5500}
  localparam logic [31:0] VEC [12] = '{
    {16'h5100, 8'h05, 8'h00},  // R3 set both
    {16'h5101, 8'h00, 8'h04},  // R4 fall toggles
    {16'h5101, 8'h01, 8'h04},  // R5 rise holds
    {16'h5101, 8'h05, 8'h04},  // R4 data bit 2 ignored
    {16'h5101, 8'h04, 8'h00},  // R4 fall toggles
    {16'h5100, 8'h00, 8'h04},  // R3 clear both
    {16'h5101, 8'h00, 8'h04},  // R5 0->0 holds
    {16'h5200, 8'h05, 8'h04},  // R2 miss
    {16'h51FE, 8'h05, 8'h00},  // R2 low bits don't care, R3
    {16'h4101, 8'h00, 8'h00},  // R2 miss
    {16'h51FF, 8'h00, 8'h04},  // R2/R4 fall
    {16'h5101, 8'hFF, 8'h04}   // R4 set edge bit, data bit 2 ignored
  };

  task automatic check(input string tag, input logic [7:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic do_read(input string tag, input logic [15:0] a, input logic oe, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1;
    #1;
    check({tag, " oe"}, {7'b0, cpu_rdata_oe}, {7'b0, oe});
    check({tag, " data"}, cpu_rdata, d);
    cpu_rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    do_read("R1 reset", 16'h5500, 1, 8'h04);
    for (int i = 0; i < 12; i++) begin
      do_write(VEC[i][31:16], VEC[i][15:8]);
      do_read($sformatf("R3/R4/R5/R2 vec%0d", i), 16'h5500, 1, VEC[i][7:0]);
    end
    do_read("R6 alias 5501", 16'h5501, 1, 8'h04);
    do_read("R6 alias 5100", 16'h5100, 1, 8'h04);
    do_read("R7 miss 5400", 16'h5400, 0, 8'h00);
    do_read("R7 miss 6500", 16'h6500, 0, 8'h00);
    // R8: edge bit is 1, F is 0; the read and a falling write share one cycle
    @(negedge clk); cpu_addr = 16'h5101; cpu_wdata = 8'h00; cpu_wr = 1; cpu_rd = 1;
    #1 check("R8 same-cycle old value", cpu_rdata, 8'h04);
    @(negedge clk); cpu_wr = 0;
    #1 check("R8 after edge", cpu_rdata, 8'h00);
    cpu_rd = 0;
    // R1: a reset in mid-run clears F
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    do_read("R1 mid-run reset", 16'h5500, 1, 8'h04);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2ms;
    bad++; total++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule